// File: doc/BRIEF.md
# Pass-Through Window Target Handler

This block stands between a simplified target-side bus front end and a slower local bus. Software configures up to four address windows. Each window has a base, a compare mask, a space type (memory or I/O) and a local data width. A target access that falls inside an enabled window is handed to local logic as a pending request. The request carries the window number, the byte enables, the direction, a burst flag and a held address and write word.

The front end stays in wait states while the local side has not answered. When local logic pulses its completion, the block returns a one-cycle acknowledge and registers the read data. If local logic stays silent for the programmed limit of wait cycles, the block answers with retry and ends the transaction.

A burst is a sequence of data phases. After the first phase, the address comes from the holding register, which steps one DWORD after each completed phase. Narrow windows steer bytes or halfwords between the selected lanes and the low end of the local data bus.

Top module: `ptw_target`

## Requirements
- R1: After reset, no local request is pending, no response flag is raised, and every window is disabled, so any access gets the miss response.
- R2: A window hits when its mask is nonzero and (address AND mask) equals (base AND mask). Writing a mask of zero disables the window.
- R3: A window whose space bit is 1 (I/O) only hits I/O accesses (fe_io=1). A window with space bit 0 only hits memory accesses.
- R4: When several windows hit, the one with the lowest index is reported on lb_region.
- R5: One clock edge after a hitting request is sampled, lb_pend rises with the region, byte enables, direction and burst flag. These values, and lb_addr, stay stable while lb_pend is high.
- R6: fe_wait is high for every cycle that lb_pend is high. fe_ack is raised for exactly one cycle, in the cycle after the edge that samples lb_done with lb_pend high.
- R7: If lb_done is not seen within RETRY_LIMIT (16) pending cycles, fe_retry is raised for one cycle and the transaction ends. A completion sampled in the sixteenth pending cycle still gives fe_ack.
- R8: A request that hits no window gives a one-cycle fe_miss and never raises lb_pend. At most one of fe_ack, fe_retry and fe_miss is high in any cycle.
- R9: When fe_more is 1, another phase follows. Each later phase of a burst uses the held DWORD address plus one DWORD (address + 4) per completed phase, and fe_addr is ignored for those phases. lb_burst shows the first phase's fe_more for the whole transaction.
- R10: Width code 0 (8-bit): the lowest enabled byte lane k (lane 0 if none) gives lb_addr[1:0]=k and lb_wdata={24'b0, byte k}. Read data is fe_rdata={4{lb_rdata[7:0]}}.
- R11: Width code 1 (16-bit): the upper half is selected when fe_be[1:0]=0 and fe_be[3:2]!=0. lb_addr[1:0] is {upper,0}, lb_wdata={16'b0, selected half}, and fe_rdata={2{lb_rdata[15:0]}}.
- R12: Width codes 2 and 3 (32-bit): lb_addr[1:0]=0, and the data passes unchanged in both directions. Byte enable bit i marks byte i (bits 8i+7..8i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one window's configuration |
| cfg_sel | input | 2 | Window index to write |
| cfg_base | input | 32 | Window base address |
| cfg_mask | input | 32 | Compare mask; zero disables the window |
| cfg_io | input | 1 | 1 = I/O space, 0 = memory space |
| cfg_width | input | 2 | Local width: 0=8, 1=16, 2/3=32 bit |
| fe_req | input | 1 | Front end presents a data phase |
| fe_addr | input | 32 | Access address (first phase only) |
| fe_io | input | 1 | Access is in I/O space |
| fe_write | input | 1 | Access is a write |
| fe_be | input | 4 | Byte enables of this phase |
| fe_wdata | input | 32 | Write data of this phase |
| fe_more | input | 1 | Another phase follows this one |
| fe_ack | output | 1 | Phase completed |
| fe_retry | output | 1 | Phase abandoned; retry later |
| fe_miss | output | 1 | No window claimed the access |
| fe_wait | output | 1 | Wait state being inserted |
| fe_rdata | output | 32 | Steered read data of last completed phase |
| lb_pend | output | 1 | Request pending to local logic |
| lb_region | output | 2 | Window that was hit |
| lb_addr | output | 32 | Held local address |
| lb_be | output | 4 | Byte enables of pending phase |
| lb_write | output | 1 | Pending phase is a write |
| lb_burst | output | 1 | Transaction is a burst |
| lb_wdata | output | 32 | Held, steered write data |
| lb_done | input | 1 | Local logic completes the pending phase |
| lb_rdata | input | 32 | Local read data, valid with lb_done |

## Verification
The hardest case to reach from the ports is the edge of the wait limit. A completion sampled in the very last allowed pending cycle must still give an acknowledge, and one cycle later it must give a retry. The same limit must also hold when the silence falls in the middle of a burst. The bench's local responder therefore completes after a chosen number of pending cycles, set per phase. Bursts are run with delays of 15, 0 and "never", mixed across their phases, to place the completion exactly on both sides of the limit and to drop a burst part way through.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
    localparam int PTW_AW = 32;
    localparam int PTW_DW = 32;
    localparam int PTW_BE = PTW_DW / 8;

    localparam logic [1:0] LW_8  = 2'd0;
    localparam logic [1:0] LW_16 = 2'd1;

    typedef struct packed {
        logic [PTW_AW-1:0] base;
        logic [PTW_AW-1:0] mask;
        logic              io;
        logic [1:0]        width;
    } window_t;

    typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_RESP, ST_NEXT} phase_e;
    typedef enum logic [1:0] {RK_NONE, RK_ACK, RK_RETRY, RK_MISS} resp_e;
endpackage

// File: rtl/ptw_cfg.sv
`timescale 1ns/1ps
module ptw_cfg
    import ptw_pkg::*;
#(
    parameter int N_REGIONS = 4,
    parameter int RW        = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [RW-1:0]                 cfg_sel,
    input  logic [PTW_AW-1:0]             cfg_base,
    input  logic [PTW_AW-1:0]             cfg_mask,
    input  logic                          cfg_io,
    input  logic [1:0]                    cfg_width,
    output window_t [N_REGIONS-1:0]       win_o
);
    for (genvar g = 0; g < N_REGIONS; g++) begin : g_win
        window_t ent_d, ent_q;
        logic    hit_sel;

        assign hit_sel = cfg_we && (cfg_sel == RW'(g));

        always_comb begin
            ent_d = ent_q;
            if (hit_sel) begin
                ent_d.base  = cfg_base;
                ent_d.mask  = cfg_mask;
                ent_d.io    = cfg_io;
                ent_d.width = cfg_width;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign win_o[g] = ent_q;
    end
endmodule

// File: rtl/ptw_decode.sv
`timescale 1ns/1ps
module ptw_decode
    import ptw_pkg::*;
#(
    parameter int N_REGIONS = 4,
    parameter int RW        = 2
) (
    input  window_t [N_REGIONS-1:0] win_i,
    input  logic [PTW_AW-1:0]       addr_i,
    input  logic                    io_i,
    output logic                    hit_o,
    output logic [RW-1:0]           idx_o,
    output logic [1:0]              width_o
);
    logic [N_REGIONS-1:0] match;

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_cmp
        assign match[g] = (win_i[g].mask != '0)
                       && (win_i[g].io == io_i)
                       && (((addr_i ^ win_i[g].base) & win_i[g].mask) == '0);
    end

    always_comb begin
        idx_o   = '0;
        width_o = win_i[0].width;
        for (int i = N_REGIONS - 1; i >= 0; i--) begin
            if (match[i]) begin
                idx_o   = RW'(i);
                width_o = win_i[i].width;
            end
        end
    end

    assign hit_o = |match;
endmodule

// File: rtl/ptw_lanes.sv
`timescale 1ns/1ps
module ptw_lanes
    import ptw_pkg::*;
(
    input  logic [1:0]        width_i,
    input  logic [PTW_BE-1:0] be_i,
    input  logic [PTW_DW-1:0] wdata_i,
    input  logic [PTW_DW-1:0] rdata_i,
    output logic [1:0]        lo_o,
    output logic [PTW_DW-1:0] wdata_o,
    output logic [PTW_DW-1:0] rdata_o
);
    logic [1:0] lane8;
    logic       upper16;

    always_comb begin
        casez (be_i)
            4'b???1: lane8 = 2'd0;
            4'b??10: lane8 = 2'd1;
            4'b?100: lane8 = 2'd2;
            4'b1000: lane8 = 2'd3;
            default: lane8 = 2'd0;
        endcase
    end

    assign upper16 = (be_i[1:0] == 2'b00) && (be_i[3:2] != 2'b00);

    always_comb begin
        unique case (width_i)
            LW_8: begin
                lo_o    = lane8;
                wdata_o = {24'd0, wdata_i[8*lane8 +: 8]};
                rdata_o = {4{rdata_i[7:0]}};
            end
            LW_16: begin
                lo_o    = {upper16, 1'b0};
                wdata_o = {16'd0, (upper16 ? wdata_i[31:16] : wdata_i[15:0])};
                rdata_o = {2{rdata_i[15:0]}};
            end
            default: begin
                lo_o    = 2'd0;
                wdata_o = wdata_i;
                rdata_o = rdata_i;
            end
        endcase
    end
endmodule

// File: rtl/ptw_target.sv
`timescale 1ns/1ps
module ptw_target
    import ptw_pkg::*;
#(
    parameter int N_REGIONS   = 4,
    parameter int RETRY_LIMIT = 16,
    localparam int RW = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1,
    localparam int CW = $clog2(RETRY_LIMIT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [RW-1:0]      cfg_sel,
    input  logic [PTW_AW-1:0]  cfg_base,
    input  logic [PTW_AW-1:0]  cfg_mask,
    input  logic               cfg_io,
    input  logic [1:0]         cfg_width,
    input  logic               fe_req,
    input  logic [PTW_AW-1:0]  fe_addr,
    input  logic               fe_io,
    input  logic               fe_write,
    input  logic [PTW_BE-1:0]  fe_be,
    input  logic [PTW_DW-1:0]  fe_wdata,
    input  logic               fe_more,
    output logic               fe_ack,
    output logic               fe_retry,
    output logic               fe_miss,
    output logic               fe_wait,
    output logic [PTW_DW-1:0]  fe_rdata,
    output logic               lb_pend,
    output logic [RW-1:0]      lb_region,
    output logic [PTW_AW-1:0]  lb_addr,
    output logic [PTW_BE-1:0]  lb_be,
    output logic               lb_write,
    output logic               lb_burst,
    output logic [PTW_DW-1:0]  lb_wdata,
    input  logic               lb_done,
    input  logic [PTW_DW-1:0]  lb_rdata
);
    typedef struct packed {
        phase_e              st;
        resp_e               kind;
        logic [CW-1:0]       cnt;
        logic [RW-1:0]       region;
        logic [PTW_AW-3:0]   dwaddr;
        logic [1:0]          lo;
        logic [PTW_BE-1:0]   be;
        logic                write;
        logic                txn_burst;
        logic                more;
        logic [1:0]          width;
        logic [PTW_DW-1:0]   wdata;
        logic [PTW_DW-1:0]   rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    window_t [N_REGIONS-1:0] win;
    logic                    dec_hit;
    logic [RW-1:0]           dec_idx;
    logic [1:0]              dec_width;
    logic [1:0]              ln_width;
    logic [1:0]              ln_lo;
    logic [PTW_DW-1:0]       ln_wdata;
    logic [PTW_DW-1:0]       ln_rdata;

    ptw_cfg #(.N_REGIONS(N_REGIONS), .RW(RW)) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_base  (cfg_base),
        .cfg_mask  (cfg_mask),
        .cfg_io    (cfg_io),
        .cfg_width (cfg_width),
        .win_o     (win)
    );

    ptw_decode #(.N_REGIONS(N_REGIONS), .RW(RW)) i_decode (
        .win_i   (win),
        .addr_i  (fe_addr),
        .io_i    (fe_io),
        .hit_o   (dec_hit),
        .idx_o   (dec_idx),
        .width_o (dec_width)
    );

    assign ln_width = (ctl_q.st == ST_IDLE) ? dec_width : ctl_q.width;

    ptw_lanes i_lanes (
        .width_i (ln_width),
        .be_i    (fe_be),
        .wdata_i (fe_wdata),
        .rdata_i (lb_rdata),
        .lo_o    (ln_lo),
        .wdata_o (ln_wdata),
        .rdata_o (ln_rdata)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (fe_req) begin
                    if (dec_hit) begin
                        ctl_d.st        = ST_BUSY;
                        ctl_d.kind      = RK_NONE;
                        ctl_d.cnt       = '0;
                        ctl_d.region    = dec_idx;
                        ctl_d.width     = dec_width;
                        ctl_d.dwaddr    = fe_addr[PTW_AW-1:2];
                        ctl_d.lo        = ln_lo;
                        ctl_d.be        = fe_be;
                        ctl_d.write     = fe_write;
                        ctl_d.txn_burst = fe_more;
                        ctl_d.more      = fe_more;
                        ctl_d.wdata     = ln_wdata;
                    end else begin
                        ctl_d.st   = ST_RESP;
                        ctl_d.kind = RK_MISS;
                        ctl_d.more = 1'b0;
                    end
                end
            end
            ST_BUSY: begin
                if (lb_done) begin
                    ctl_d.st    = ST_RESP;
                    ctl_d.kind  = RK_ACK;
                    ctl_d.rdata = ln_rdata;
                    if (ctl_q.more) ctl_d.dwaddr = ctl_q.dwaddr + 1'b1;
                end else if (ctl_q.cnt == CW'(RETRY_LIMIT - 1)) begin
                    ctl_d.st   = ST_RESP;
                    ctl_d.kind = RK_RETRY;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_RESP: begin
                ctl_d.kind = RK_NONE;
                if ((ctl_q.kind == RK_ACK) && ctl_q.more) begin
                    ctl_d.st = ST_NEXT;
                end else begin
                    ctl_d.st        = ST_IDLE;
                    ctl_d.txn_burst = 1'b0;
                end
            end
            default: begin
                if (fe_req) begin
                    ctl_d.st    = ST_BUSY;
                    ctl_d.cnt   = '0;
                    ctl_d.lo    = ln_lo;
                    ctl_d.be    = fe_be;
                    ctl_d.wdata = ln_wdata;
                    ctl_d.more  = fe_more;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign lb_pend   = (ctl_q.st == ST_BUSY);
    assign fe_wait   = lb_pend;
    assign fe_ack    = (ctl_q.st == ST_RESP) && (ctl_q.kind == RK_ACK);
    assign fe_retry  = (ctl_q.st == ST_RESP) && (ctl_q.kind == RK_RETRY);
    assign fe_miss   = (ctl_q.st == ST_RESP) && (ctl_q.kind == RK_MISS);
    assign fe_rdata  = ctl_q.rdata;
    assign lb_region = ctl_q.region;
    assign lb_addr   = {ctl_q.dwaddr, ctl_q.lo};
    assign lb_be     = ctl_q.be;
    assign lb_write  = ctl_q.write;
    assign lb_burst  = ctl_q.txn_burst;
    assign lb_wdata  = ctl_q.wdata;

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fe_ack, fe_retry, fe_miss})); // R8
    AST_ACK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fe_ack |-> $past(lb_pend && lb_done)); // R6
    AST_RETRY_UNSERVED: assert property (@(posedge clk) disable iff (!rst_n)
        fe_retry |-> $past(lb_pend && !lb_done)); // R7
    AST_PEND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_pend && $past(lb_pend)) |-> ($stable(lb_addr) && $stable(lb_region) && $stable(lb_be))); // R5
    AST_MISS_NO_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        fe_miss |-> (!lb_pend && !$past(lb_pend))); // R8
    AST_WAIT_WITH_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        lb_pend |-> (fe_wait && !fe_ack && !fe_retry)); // R6
endmodule

// File: tb/test_ptw_target.sv
`timescale 1ns/1ps
module test_ptw_target;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_base = '0;
    logic [31:0] cfg_mask = '0;
    logic        cfg_io = 1'b0;
    logic [1:0]  cfg_width = '0;
    logic        fe_req = 1'b0;
    logic [31:0] fe_addr = '0;
    logic        fe_io = 1'b0;
    logic        fe_write = 1'b0;
    logic [3:0]  fe_be = '0;
    logic [31:0] fe_wdata = '0;
    logic        fe_more = 1'b0;
    logic        fe_ack, fe_retry, fe_miss, fe_wait;
    logic [31:0] fe_rdata;
    logic        lb_pend;
    logic [1:0]  lb_region;
    logic [31:0] lb_addr;
    logic [3:0]  lb_be;
    logic        lb_write, lb_burst;
    logic [31:0] lb_wdata;
    logic        lb_done = 1'b0;
    logic [31:0] lb_rdata = '0;

    ptw_target i_ptw_target (.*);

    always #2.5 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    // configuration mirror
    logic [31:0] cb [4];
    logic [31:0] cm [4];
    logic        cio [4];
    logic [1:0]  cw [4];

    // reference model state: 0 idle, 1 busy, 2 resp, 3 next; kind 1 ack, 2 retry, 3 miss
    int          ms = 0, mk = 0, mcnt = 0, mreg = 0;
    logic [29:0] mdw = '0;
    logic [1:0]  mlo = '0, mwd = '0;
    logic [3:0]  mbe = '0;
    logic        mwr = 0, mtb = 0, mmore = 0;
    logic [31:0] mwdat = '0, mrdat = '0;

    int resp_delay = 0;
    int pcount = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int lane_of(input logic [3:0] be);
        int l = 0;
        for (int k = 3; k >= 0; k--) if (be[k]) l = k;
        return l;
    endfunction

    function automatic logic [1:0] low_bits(input logic [1:0] w, input logic [3:0] be);
        if (w == 2'd0) return 2'(lane_of(be));
        if (w == 2'd1) return (be[1:0] == 2'b00 && be[3:2] != 2'b00) ? 2'd2 : 2'd0;
        return 2'd0;
    endfunction

    function automatic logic [31:0] wsteer(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
        if (w == 2'd0) return (d >> (8 * lane_of(be))) & 32'h0000_00FF;
        if (w == 2'd1) return (be[1:0] == 2'b00 && be[3:2] != 2'b00) ? (d >> 16) : (d & 32'h0000_FFFF);
        return d;
    endfunction

    function automatic logic [31:0] rsteer(input logic [1:0] w, input logic [31:0] d);
        if (w == 2'd0) return {d[7:0], d[7:0], d[7:0], d[7:0]};
        if (w == 2'd1) return {d[15:0], d[15:0]};
        return d;
    endfunction

    function automatic int find_win(input logic [31:0] a, input logic io);
        for (int i = 0; i < 4; i++)
            if (cm[i] != 0 && cio[i] == io && ((a & cm[i]) == (cb[i] & cm[i]))) return i;
        return -1;
    endfunction

    function automatic string wtag(input logic [1:0] w);
        if (w == 2'd0) return "R10 narrow8";
        if (w == 2'd1) return "R11 narrow16";
        return "R12 full32";
    endfunction

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mk = 0; mcnt = 0; mtb = 0; mrdat = '0; mdw = '0; mlo = '0;
        end else begin
            case (ms)
                0: if (fe_req) begin
                    int r;
                    r = find_win(fe_addr, fe_io);
                    if (r >= 0) begin
                        ms = 1; mcnt = 0; mreg = r; mwd = cw[r];
                        mdw = fe_addr[31:2]; mbe = fe_be; mwr = fe_write;
                        mtb = fe_more; mmore = fe_more;
                        mlo = low_bits(mwd, fe_be); mwdat = wsteer(mwd, fe_be, fe_wdata);
                    end else begin
                        ms = 2; mk = 3; mmore = 0;
                    end
                end
                1: if (lb_done) begin
                    ms = 2; mk = 1; mrdat = rsteer(mwd, lb_rdata);
                    if (mmore) mdw = mdw + 30'd1;
                end else if (mcnt == 15) begin
                    ms = 2; mk = 2;
                end else begin
                    mcnt++;
                end
                2: begin
                    if (mk == 1 && mmore) ms = 3;
                    else begin ms = 0; mtb = 0; end
                    mk = 0;
                end
                default: if (fe_req) begin
                    ms = 1; mcnt = 0; mbe = fe_be; mmore = fe_more;
                    mlo = low_bits(mwd, fe_be); mwdat = wsteer(mwd, fe_be, fe_wdata);
                end
            endcase
        end
    end

    // cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R6 lb_pend", {31'd0, lb_pend}, {31'd0, ms == 1});
            chk("R6 fe_wait", {31'd0, fe_wait}, {31'd0, ms == 1});
            chk("R6 fe_ack", {31'd0, fe_ack}, {31'd0, ms == 2 && mk == 1});
            chk("R7 fe_retry", {31'd0, fe_retry}, {31'd0, ms == 2 && mk == 2});
            chk("R8 fe_miss", {31'd0, fe_miss}, {31'd0, ms == 2 && mk == 3});
            if (ms == 1) begin
                chk("R4 lb_region", {30'd0, lb_region}, 32'(mreg));
                chk("R9 lb_addr", lb_addr, {mdw, mlo});
                chk("R5 lb_be", {28'd0, lb_be}, {28'd0, mbe});
                chk("R5 lb_write", {31'd0, lb_write}, {31'd0, mwr});
                chk("R9 lb_burst", {31'd0, lb_burst}, {31'd0, mtb});
                chk(wtag(mwd), lb_wdata, mwdat);
            end
            if (ms == 2 && mk == 1 && !mwr) chk(wtag(mwd), fe_rdata, mrdat);
        end
    end

    // local responder: completes after resp_delay pending cycles (large = never)
    always @(negedge clk) begin
        if (lb_pend) begin
            lb_done = (pcount == resp_delay);
            pcount++;
        end else begin
            lb_done = 1'b0;
            pcount = 0;
        end
    end

    task automatic set_win(input int i, input logic [31:0] b, input logic [31:0] m,
                           input logic io, input logic [1:0] w);
        cfg_sel = 2'(i); cfg_base = b; cfg_mask = m; cfg_io = io; cfg_width = w; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        cb[i] = b; cm[i] = m; cio[i] = io; cw[i] = w;
    endtask

    // one data phase; expected kind 1 ack, 2 retry, 3 miss
    task automatic phase(input string tag, input logic [31:0] a, input logic io, input logic wr,
                         input logic [3:0] be, input logic [31:0] wd, input logic more,
                         input int dly, input logic [31:0] rd, input int exp_kind);
        int got = 0;
        fe_req = 1'b1; fe_addr = a; fe_io = io; fe_write = wr; fe_be = be;
        fe_wdata = wd; fe_more = more; resp_delay = dly; lb_rdata = rd;
        for (int n = 0; n < 100; n++) begin
            @(negedge clk);
            if (fe_ack) begin got = 1; break; end
            if (fe_retry) begin got = 2; break; end
            if (fe_miss) begin got = 3; break; end
        end
        chk(tag, 32'(got), 32'(exp_kind));
        fe_req = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin cb[i] = '0; cm[i] = '0; cio[i] = 1'b0; cw[i] = '0; end
        repeat (3) @(negedge clk);
        chk("R1 reset pend", {31'd0, lb_pend}, 32'd0);
        chk("R1 reset flags", {29'd0, fe_ack, fe_retry, fe_miss}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        phase("R1 all windows disabled", 32'h1000_0000, 1'b0, 1'b0, 4'hF, 0, 1'b0, 0, 0, 3);

        set_win(0, 32'h1000_0000, 32'hF000_0000, 1'b0, 2'd2);
        set_win(1, 32'h2000_0000, 32'hFFFF_0000, 1'b0, 2'd1);
        set_win(2, 32'h0000_0300, 32'hFFFF_FF00, 1'b1, 2'd0);
        set_win(3, 32'h1000_0000, 32'hFFF0_0000, 1'b0, 2'd0);
        @(negedge clk);

        phase("R2 hit window0 read", 32'h1234_5678, 1'b0, 1'b0, 4'hF, 0, 1'b0, 0, 32'hCAFE_F00D, 1);
        phase("R4 overlap read", 32'h1000_0040, 1'b0, 1'b0, 4'hF, 0, 1'b0, 3, 32'h0BAD_BEEF, 1);
        phase("R12 write", 32'h1F00_0010, 1'b0, 1'b1, 4'h6, 32'hA1B2_C3D4, 1'b0, 2, 0, 1);
        phase("R2 outside windows", 32'h3000_0000, 1'b0, 1'b0, 4'hF, 0, 1'b0, 0, 0, 3);
        phase("R3 io hit", 32'h0000_0344, 1'b1, 1'b0, 4'h8, 0, 1'b0, 1, 32'h0000_005A, 1);
        phase("R3 memory misses io window", 32'h0000_0344, 1'b0, 1'b0, 4'hF, 0, 1'b0, 0, 0, 3);
        phase("R3 io misses memory window", 32'h1000_0000, 1'b1, 1'b0, 4'hF, 0, 1'b0, 0, 0, 3);
        phase("R10 write lane2", 32'h0000_0300, 1'b1, 1'b1, 4'h4, 32'h1122_3344, 1'b0, 0, 0, 1);
        phase("R10 write no lanes", 32'h0000_0308, 1'b1, 1'b1, 4'h0, 32'h1122_3344, 1'b0, 0, 0, 1);
        phase("R11 write upper", 32'h2000_1000, 1'b0, 1'b1, 4'hC, 32'h8765_4321, 1'b0, 0, 0, 1);
        phase("R11 read lower", 32'h2000_1004, 1'b0, 1'b0, 4'h3, 0, 1'b0, 4, 32'h9999_1357, 1);
        phase("R11 mixed lanes low", 32'h2000_1008, 1'b0, 1'b1, 4'h6, 32'hDEAD_BEEF, 1'b0, 0, 0, 1);

        phase("R7 silent local side", 32'h1000_0100, 1'b0, 1'b0, 4'hF, 0, 1'b0, 1000, 0, 2);
        phase("R7 done on last wait", 32'h1000_0104, 1'b0, 1'b0, 4'hF, 0, 1'b0, 15, 32'h7777_0001, 1);

        phase("R9 burst p0", 32'h1000_0200, 1'b0, 1'b0, 4'hF, 0, 1'b1, 0, 32'h0000_0A00, 1);
        phase("R9 burst p1", 32'hFFFF_FFFC, 1'b1, 1'b0, 4'h3, 0, 1'b1, 2, 32'h0000_0A01, 1);
        phase("R9 burst p2", 32'h0000_0000, 1'b0, 1'b0, 4'hF, 0, 1'b1, 15, 32'h0000_0A02, 1);
        phase("R9 burst p3", 32'h5555_5555, 1'b0, 1'b0, 4'hC, 0, 1'b0, 0, 32'h0000_0A03, 1);
        phase("R9 after burst single", 32'h1000_0300, 1'b0, 1'b0, 4'hF, 0, 1'b0, 0, 32'h1, 1);

        phase("R9 narrow burst p0", 32'h2000_0010, 1'b0, 1'b1, 4'h1, 32'h0000_AAAA, 1'b1, 0, 0, 1);
        phase("R9 narrow burst p1", 32'h0, 1'b0, 1'b1, 4'h8, 32'hBBBB_0000, 1'b0, 1, 0, 1);

        phase("R7 burst retry p0", 32'h1000_0400, 1'b0, 1'b1, 4'hF, 32'h0102_0304, 1'b1, 0, 0, 1);
        phase("R7 burst retry p1", 32'h0, 1'b0, 1'b1, 4'hF, 32'h0506_0708, 1'b1, 1000, 0, 2);
        phase("R7 idle after retry", 32'h3000_0000, 1'b0, 1'b0, 4'hF, 0, 1'b0, 0, 0, 3);

        set_win(0, 32'h1000_0000, 32'h0000_0000, 1'b0, 2'd2);
        phase("R2 zero mask falls to window3", 32'h1000_0080, 1'b0, 1'b0, 4'h2, 0, 1'b0, 0, 32'h0000_00C3, 1);
        phase("R2 disabled window0 miss", 32'h1800_0000, 1'b0, 1'b0, 4'hF, 0, 1'b0, 0, 0, 3);

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule